// File: doc/BRIEF.md
# VCO Subband Search Controller

This controller decides which oscillator subband a frequency synthesizer runs on. There are 31 subbands, coded 0 to 30. On a start strobe the controller either copies a programmed subband straight to its output or runs an automatic search. The automatic search is confined to one of four overlapping windows of ten contiguous subbands, and the four windows together cover all 31 codes.

In automatic mode the controller probes candidate subbands by halving an interval. It drives a candidate on `band_o` and waits a fixed settling count. It then samples a one-bit comparison from an external frequency counter, which reports whether the oscillator on the current subband runs above the target. The controller keeps the half of the interval that must hold the answer. The search ends on the highest subband in the window whose frequency is at or below the target. If every candidate in the window runs above the target, it ends on the bottom of the window.

The finite-state machine has four states:
- `ST_IDLE` holds the last result. Start in automatic mode moves it to `ST_SETTLE`. Start in manual mode stays in `ST_IDLE` and loads the programmed code.
- `ST_SETTLE` holds the current candidate. When the interval has shrunk to one code it moves to `ST_LAND`. Otherwise, when the settle count expires, it moves to `ST_JUDGE`.
- `ST_JUDGE` samples the comparison, narrows the interval and returns to `ST_SETTLE`.
- `ST_LAND` stores the result, pulses done and returns to `ST_IDLE`.

Top module: `vco_band_picker`

## Requirements
- R1: After reset `band_o` is 0, `busy_o` is 0 and `done_o` is 0.
- R2: Manual mode works as follows. A start accepted with `auto_i`=0 drives the programmed code to `band_o` one cycle later and pulses `done_o` in that cycle, and `busy_o` stays 0. A programmed value of 31 is saturated to 30.
- R3: Window `win_sel_i`=w has its base at subband 7*w, so the bases are 0, 7, 14 and 21. The candidates are base to base+9. While `busy_o` is 1, `band_o` stays inside the window that was latched at start.
- R4: `vco_fast_i`=1 means the oscillator on the present `band_o` runs above the target. An automatic search ends with `band_o` equal to the highest candidate in the window for which `vco_fast_i` is 0. If `vco_fast_i` is 1 for every candidate, the result is the window base. This assumes frequency rises with the subband code.
- R5: An automatic search makes at most 4 comparisons. Each candidate is held for SETTLE_CYC cycles before its comparison is sampled. `done_o` pulses no later than 4*(SETTLE_CYC+1)+3 cycles after the cycle in which start was driven.
- R6: `busy_o` is 1 from the cycle after an accepted automatic start until the result lands. `done_o` is a one-cycle pulse, one per accepted start, and it is never high together with `busy_o`.
- R7: A start strobe while `busy_o` is 1 is ignored. Mode, programmed code and window changes during a search do not alter its result, and no extra done pulse appears.
- R8: Between searches `band_o` is stable, whatever `vco_fast_i`, `prog_band_i`, `win_sel_i` and `auto_i` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, honoured only when idle |
| auto_i | input | 1 | 1 = automatic search, 0 = use programmed code |
| prog_band_i | input | 5 | Programmed subband for manual mode |
| win_sel_i | input | 2 | Search window select (base 7*w) |
| vco_fast_i | input | 1 | Counter comparison: oscillator above target |
| band_o | output | 5 | Subband code driven to the oscillator bank |
| busy_o | output | 1 | Automatic search in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `vco_fast_i` is a monotonic function of `band_o`, so that an answer exists where the halving expects it. They also assume that the comparison is valid once the settle count has run. The bench models the counter as a threshold compare on the live `band_o` against a target subband index, which gives both properties by construction. The bench keeps every start a single-cycle pulse. It issues starts during a search only in the test that checks they are ignored, and in that test it changes mode, window and programmed code but not the target.

// File: rtl/vbp_pkg.sv
`timescale 1ns/1ps
package vbp_pkg;
    localparam int BAND_W     = 5;
    localparam int NUM_BANDS  = 31;
    localparam int WIN_SPAN   = 10;
    localparam int WIN_STRIDE = 7;
    localparam int NUM_WIN    = 4;
    localparam int WIN_W      = $clog2(NUM_WIN);
    localparam int OFF_W      = $clog2(WIN_SPAN);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_JUDGE,
        ST_LAND
    } vbp_state_e;
endpackage

// File: rtl/vbp_window_base.sv
`timescale 1ns/1ps
module vbp_window_base
    import vbp_pkg::*;
(
    input  logic [WIN_W-1:0]  sel_i,
    output logic [BAND_W-1:0] base_o
);
    logic [BAND_W-1:0] base_tbl [NUM_WIN];

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_base
        assign base_tbl[w] = BAND_W'(w * WIN_STRIDE);
    end

    assign base_o = base_tbl[sel_i];

    // R3: the highest window must end on the top subband or below it
    always_comb begin
        p_window_fits_r3: assert (int'(base_o) + WIN_SPAN - 1 <= NUM_BANDS - 1)
            else $error("window beyond last subband");
    end
endmodule

// File: rtl/vbp_settle_timer.sv
`timescale 1ns/1ps
module vbp_settle_timer #(
    parameter int SETTLE_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int CNT_W = $clog2(SETTLE_CYC) + 1;

    logic [CNT_W-1:0] cnt_q;

    assign expired_o = run_i && (cnt_q == CNT_W'(SETTLE_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run_i)
            cnt_q <= '0;
        else if (!expired_o)
            cnt_q <= cnt_q + 1'b1;
    end

    p_count_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) <= SETTLE_CYC - 1)
        else $error("settle counter ran past its limit");

    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0))
        else $error("settle counter not cleared between candidates");
endmodule

// File: rtl/vbp_halving.sv
`timescale 1ns/1ps
module vbp_halving #(
    parameter int SPAN = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_i,
    input  logic                      step_i,
    input  logic                      too_fast_i,
    output logic [$clog2(SPAN)-1:0]   probe_o,
    output logic [$clog2(SPAN)-1:0]   result_o,
    output logic                      last_o
);
    localparam int OW        = $clog2(SPAN);
    localparam int MAX_STEPS = $clog2(SPAN);
    localparam int STEP_W    = $clog2(MAX_STEPS + 1);

    logic [OW-1:0]     lo_q, hi_q;
    logic [OW:0]       sum_w;
    logic [OW-1:0]     mid_w;
    logic [STEP_W-1:0] steps_q;

    // upper middle, so a step always moves one bound
    assign sum_w    = {1'b0, lo_q} + {1'b0, hi_q} + 1'b1;
    assign mid_w    = OW'(sum_w >> 1);
    assign probe_o  = mid_w;
    assign result_o = lo_q;
    assign last_o   = (lo_q == hi_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q    <= '0;
            hi_q    <= '0;
            steps_q <= '0;
        end else if (load_i) begin
            lo_q    <= '0;
            hi_q    <= OW'(SPAN - 1);
            steps_q <= '0;
        end else if (step_i) begin
            if (too_fast_i)
                hi_q <= mid_w - 1'b1;
            else
                lo_q <= mid_w;
            steps_q <= steps_q + 1'b1;
        end
    end

    p_lo_le_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lo_q <= hi_q)
        else $error("search interval inverted");

    p_hi_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(hi_q) <= SPAN - 1)
        else $error("search interval left the window");

    p_step_budget_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> (int'(steps_q) < MAX_STEPS))
        else $error("more comparisons than the halving bound");

    p_step_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> !last_o)
        else $error("comparison made on a closed interval");
endmodule

// File: rtl/vco_band_picker.sv
`timescale 1ns/1ps
module vco_band_picker
    import vbp_pkg::*;
#(
    parameter int SETTLE_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              auto_i,
    input  logic [BAND_W-1:0] prog_band_i,
    input  logic [WIN_W-1:0]  win_sel_i,
    input  logic              vco_fast_i,
    output logic [BAND_W-1:0] band_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam logic [BAND_W-1:0] TOP_CODE = BAND_W'(NUM_BANDS - 1);

    vbp_state_e        state_q, state_d;
    logic [BAND_W-1:0] band_q, base_q, base_w, prog_lim;
    logic              done_q;
    logic              accept, expired, last;
    logic [OFF_W-1:0]  probe, result;

    assign accept   = (state_q == ST_IDLE) && start_i;
    assign prog_lim = (prog_band_i > TOP_CODE) ? TOP_CODE : prog_band_i;

    vbp_window_base u_base (
        .sel_i  (win_sel_i),
        .base_o (base_w)
    );

    vbp_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (state_q == ST_SETTLE),
        .expired_o (expired)
    );

    vbp_halving #(.SPAN(WIN_SPAN)) u_halve (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept && auto_i),
        .step_i     (state_q == ST_JUDGE),
        .too_fast_i (vco_fast_i),
        .probe_o    (probe),
        .result_o   (result),
        .last_o     (last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i && auto_i) state_d = ST_SETTLE;
            ST_SETTLE: if (last)              state_d = ST_LAND;
                       else if (expired)      state_d = ST_JUDGE;
            ST_JUDGE:                         state_d = ST_SETTLE;
            ST_LAND:                          state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            band_q <= '0;
            base_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                if (auto_i) begin
                    base_q <= base_w;
                end else begin
                    band_q <= prog_lim;
                    done_q <= 1'b1;
                end
            end else if (state_q == ST_LAND) begin
                band_q <= base_q + BAND_W'(result);
                done_q <= 1'b1;
            end
        end
    end

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = done_q;
    assign band_o = busy_o ? (base_q + BAND_W'(probe)) : band_q;

    p_manual_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !auto_i) |=>
            (done_o && !busy_o &&
             band_o == (($past(prog_band_i) > TOP_CODE) ? TOP_CODE : $past(prog_band_i))))
        else $error("manual load wrong");

    p_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (band_o >= base_q && int'(band_o) <= int'(base_q) + WIN_SPAN - 1))
        else $error("candidate outside window");

    p_settle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && !expired && !last) |=> $stable(band_o))
        else $error("candidate changed while settling");

    p_busy_after_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && auto_i) |=> busy_o)
        else $error("search did not begin");

    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o)
        else $error("done while busy");

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(band_o))
        else $error("band moved between searches");
endmodule

// File: tb/vco_band_picker_test.sv
`timescale 1ns/1ps
module vco_band_picker_test;
    localparam int S     = 6;
    localparam int BOUND = 4 * (S + 1) + 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       auto_m = 1'b0;
    logic [4:0] prog = '0;
    logic [1:0] sel = '0;
    int         target = 0;
    logic       fast;
    logic [4:0] band;
    logic       busy, done;

    int cyc = 0;
    int errs = 0;
    int checks = 0;

    typedef struct {
        int band;
        bit is_auto;
        int t0;
    } item_t;
    item_t exp_q[$];

    vco_band_picker #(.SETTLE_CYC(S)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .auto_i      (auto_m),
        .prog_band_i (prog),
        .win_sel_i   (sel),
        .vco_fast_i  (fast),
        .band_o      (band),
        .busy_o      (busy),
        .done_o      (done)
    );

    // frequency counter model: oscillator above target when code exceeds it
    assign fast = (int'(band) > target);

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int model_auto(input int s, input int t);
        int base;
        base = 7 * s;
        if (t < base)     return base;
        if (t > base + 9) return base + 9;
        return t;
    endfunction

    // driver: one start pulse, expected item pushed to the scoreboard
    task automatic launch(input bit a, input int p, input int s, input int t);
        item_t it;
        @(negedge clk);
        auto_m = a;
        prog   = 5'(p);
        sel    = 2'(s);
        target = t;
        start  = 1'b1;
        it.is_auto = a;
        it.t0      = cyc;
        it.band    = a ? model_auto(s, t) : ((p > 30) ? 30 : p);
        exp_q.push_back(it);
        @(negedge clk);
        start = 1'b0;
        if (a) check(busy == 1'b1, "R6 busy after auto start", int'(busy), 1);
        else   check(busy == 1'b0, "R2 busy stays low in manual", int'(busy), 0);
    endtask

    task automatic wait_idle();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: compare each completion against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                check(busy == 1'b0, "R6 done with busy low", int'(busy), 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected done pulse", 1, 0);
                end else begin
                    item_t it;
                    int lat;
                    it  = exp_q.pop_front();
                    lat = cyc - it.t0;
                    if (it.is_auto) begin
                        check(int'(band) == it.band, "R4 search result", int'(band), it.band);
                        check(lat <= BOUND, "R5 search latency", lat, BOUND);
                    end else begin
                        check(int'(band) == it.band, "R2 manual code", int'(band), it.band);
                        check(lat == 1, "R2 manual latency", lat, 1);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog R5 actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(band == 5'd0, "R1 band after reset", int'(band), 0);
        check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        check(done == 1'b0, "R1 done after reset", int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: manual loads, including saturation of 31
        launch(1'b0, 12, 0, 0); wait_idle();
        launch(1'b0, 31, 2, 0); wait_idle();
        launch(1'b0, 0, 3, 0);  wait_idle();

        // R3 R4 R5: every window, targets below, inside, at edges and above
        begin
            int w0 [6] = '{3, 9, 15, -1, 0, 5};
            foreach (w0[i]) begin launch(1'b1, 0, 0, w0[i]); wait_idle(); end
        end
        begin
            int w1 [5] = '{7, 10, 16, 20, 2};
            foreach (w1[i]) begin launch(1'b1, 0, 1, w1[i]); wait_idle(); end
        end
        begin
            int w2 [4] = '{14, 19, 23, 30};
            foreach (w2[i]) begin launch(1'b1, 0, 2, w2[i]); wait_idle(); end
        end
        begin
            int w3 [5] = '{21, 25, 30, 31, 10};
            foreach (w3[i]) begin launch(1'b1, 0, 3, w3[i]); wait_idle(); end
        end

        // R2 right after an automatic result
        launch(1'b0, 18, 1, 0); wait_idle();

        // R7: start pulses during a search with other mode, code and window
        launch(1'b1, 0, 0, 3);
        repeat (4) @(negedge clk);
        auto_m = 1'b0; prog = 5'd20; sel = 2'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R7 busy kept after ignored start", int'(busy), 1);
        repeat (3) @(negedge clk);
        auto_m = 1'b1; sel = 2'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        check(int'(band) == 3, "R7 result unaffected by ignored start", int'(band), 3);

        // R8: idle outputs hold while every other input moves
        begin
            int held;
            held = int'(band);
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                prog   = 5'(k * 3);
                sel    = 2'(k);
                auto_m = k[0];
                target = (k % 2 == 0) ? -1 : 40;
            end
            check(int'(band) == held, "R8 band held while idle", int'(band), held);
            check(done == 1'b0, "R8 no done while idle", int'(done), 0);
        end

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R6 every start completed", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule